// File: doc/BRIEF.md
# Two-Operand ALU with Status Flags

This block is the arithmetic and logic unit behind the two-operand instruction group of a small 16-bit core. It receives the 4-bit opcode, a byte/word select, the source and destination operand values and the incoming carry. It returns the result, a write-enable for the destination and a flag-update enable. It also returns the new negative, zero, carry and overflow flags. Every operation has the form dst = src OP dst. Subtraction is the destination plus the inverted source plus a carry. Compare and bit test only set flags. Move, bit clear and bit set leave the flags alone.

Operands are taken in the cycle where `in_valid` is high, and all outputs are registered, so they appear one clock later. The flag outputs hold their last updated value until an operation that updates flags arrives. Operand fetch, addressing modes and register storage belong to the surrounding core.

Top module: `dual_op_alu`

## Requirements
- R1: Opcode 0100 (move) produces result = src with `wr_en` = 1 and `flag_en` = 0. All four flag outputs keep their previous values.
- R2: Opcode 0101 (add) produces dst + src, and opcode 0110 (add with carry) produces dst + src + `carry_in`. C is the carry out of the top bit of the operation width. V is set when both addends have the same sign and the result sign differs from it.
- R3: Opcode 0111 (subtract with carry) produces dst + ~src + `carry_in`, and opcode 1000 (subtract) produces dst + ~src + 1. C is the carry out of that sum, so C = 1 means no borrow. V is set on signed overflow of that sum.
- R4: Opcode 1001 (compare) computes the same result and flags as subtract with `flag_en` = 1, but with `wr_en` = 0.
- R5: Opcode 1010 (decimal add) adds dst + src + `carry_in` one 4-bit digit at a time, starting at the lowest digit. A digit sum above 9 is corrected by +6 and carries 1 into the next digit. C is the carry out of the top digit and V is 0.
- R6: Opcode 1111 (and) writes dst & src. Opcode 1011 (bit test) computes the same value with `wr_en` = 0. For both, C = not Z and V = 0.
- R7: Opcode 1110 (xor) writes dst ^ src with C = not Z. V = 1 exactly when both operands are negative.
- R8: Opcode 1100 (bit clear) writes dst & ~src, and opcode 1101 (bit set) writes dst | src. Both have `flag_en` = 0 and leave all four flag outputs unchanged.
- R9: With `byte_op` = 1, the operation works on bits 7:0. N comes from bit 7, Z from bits 7:0 and C from the carry out of bit 7, and result bits 15:8 are 0.
- R10: Outputs are registered: an operation taken with `in_valid` = 1 appears on the outputs one clock later. When `in_valid` = 0, or the opcode is 0000 to 0011, the next cycle has `wr_en` = 0 and `flag_en` = 0, and the flags are unchanged.
- R11: Synchronous reset clears `result`, `wr_en`, `flag_en` and all four flags to 0.
- R12: N is the top bit of the result at the operation width, and Z is 1 exactly when the result at that width is zero. These apply to every operation that updates flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op_code | input | 4 | Two-operand opcode |
| byte_op | input | 1 | 1 = byte operation, 0 = word operation |
| src_val | input | 16 | Source operand value |
| dst_val | input | 16 | Destination operand value |
| carry_in | input | 1 | Incoming carry flag |
| result | output | 16 | Registered operation result |
| wr_en | output | 1 | Destination should be written |
| flag_en | output | 1 | Flags were updated by this operation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
A decimal carry out of the top digit and a zero result can occur in the same operation. The bench provokes this with word 9999 + 0001 and with byte 99 + 00 plus an incoming carry, and expects a zero result together with Z = 1 and C = 1. Byte-width narrowing and signed overflow can also occur together. The bench provokes this with a byte add whose operands have set upper bits: it expects bits 15:8 cleared while V and C are taken from bit 7. Every result is compared with a reference model inside the bench that keeps its own copy of the held flags.

// File: rtl/alu2_pkg.sv
package alu2_pkg;
  typedef enum logic [3:0] {
    OPC_MOV  = 4'h4,
    OPC_ADD  = 4'h5,
    OPC_ADDC = 4'h6,
    OPC_SUBC = 4'h7,
    OPC_SUB  = 4'h8,
    OPC_CMP  = 4'h9,
    OPC_DADD = 4'hA,
    OPC_BIT  = 4'hB,
    OPC_BIC  = 4'hC,
    OPC_BIS  = 4'hD,
    OPC_XOR  = 4'hE,
    OPC_AND  = 4'hF
  } opc_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_CLR = 2'd1,
    BW_SET = 2'd2,
    BW_XOR = 2'd3
  } bw_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu2_addsub.sv
module alu2_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          byte_op,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  localparam int BW = DW / 2;

  logic [DW:0] wide;
  logic [BW:0] narrow;
  logic        sa, sb, sr;

  assign wide   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  assign narrow = {1'b0, a[BW-1:0]} + {1'b0, b[BW-1:0]} + {{BW{1'b0}}, cin};

  always_comb begin
    if (byte_op) begin
      sum  = {{(DW-BW){1'b0}}, narrow[BW-1:0]};
      cout = narrow[BW];
      sa   = a[BW-1];
      sb   = b[BW-1];
      sr   = narrow[BW-1];
    end else begin
      sum  = wide[DW-1:0];
      cout = wide[DW];
      sa   = a[DW-1];
      sb   = b[DW-1];
      sr   = wide[DW-1];
    end
    ovf = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu2_bcd.sv
module alu2_bcd #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          byte_op,
  output logic [DW-1:0] sum,
  output logic          cout
);
  localparam int ND = DW / 4;
  localparam int NB = ND / 2;

  logic [4:0] dsum [ND];
  logic [ND:0] dcy;

  always_comb begin
    dcy[0] = cin;
    sum    = '0;
    for (int k = 0; k < ND; k++) begin
      dsum[k] = {1'b0, a[4*k +: 4]} + {1'b0, b[4*k +: 4]} + {4'd0, dcy[k]};
      if (dsum[k] > 5'd9) begin
        sum[4*k +: 4] = dsum[k][3:0] + 4'd6;
        dcy[k+1]      = 1'b1;
      end else begin
        sum[4*k +: 4] = dsum[k][3:0];
        dcy[k+1]      = 1'b0;
      end
    end
    if (byte_op) begin
      sum[DW-1:4*NB] = '0;
      cout           = dcy[NB];
    end else begin
      cout = dcy[ND];
    end
  end
endmodule

// File: rtl/alu2_bitwise.sv
module alu2_bitwise #(
  parameter int DW = 16
) (
  input  alu2_pkg::bw_kind_e kind,
  input  logic [DW-1:0]      s,
  input  logic [DW-1:0]      d,
  output logic [DW-1:0]      res
);
  import alu2_pkg::*;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      unique case (kind)
        BW_AND:  res[i] = d[i] & s[i];
        BW_CLR:  res[i] = d[i] & ~s[i];
        BW_SET:  res[i] = d[i] | s[i];
        default: res[i] = d[i] ^ s[i];
      endcase
    end
  end
endmodule

// File: rtl/dual_op_alu.sv
module dual_op_alu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op_code,
  input  logic          byte_op,
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] dst_val,
  input  logic          carry_in,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic          flag_en,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v
);
  import alu2_pkg::*;
  localparam int BW = DW / 2;

  opc_e          opc;
  logic          in_group;
  logic          is_sub;
  logic          as_cin;
  logic [DW-1:0] as_b;
  logic [DW-1:0] as_sum;
  logic          as_cout, as_ovf;
  logic [DW-1:0] bcd_sum;
  logic          bcd_cout;
  bw_kind_e      bw_kind;
  logic [DW-1:0] bw_res;
  logic [DW-1:0] raw_res, fin_res;
  logic          do_wr, do_flags;
  logic          r_msb, r_zero, s_msb, d_msb;
  flags_t        nf, fq;

  assign opc      = opc_e'(op_code);
  assign in_group = op_code[3] | op_code[2];
  assign is_sub   = (opc == OPC_SUBC) || (opc == OPC_SUB) || (opc == OPC_CMP);
  assign as_b     = is_sub ? ~src_val : src_val;

  always_comb begin
    unique case (opc)
      OPC_ADD:              as_cin = 1'b0;
      OPC_SUB, OPC_CMP:     as_cin = 1'b1;
      default:              as_cin = carry_in;
    endcase
  end

  alu2_addsub #(.DW(DW)) u_addsub (
    .a(dst_val), .b(as_b), .cin(as_cin), .byte_op(byte_op),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu2_bcd #(.DW(DW)) u_bcd (
    .a(dst_val), .b(src_val), .cin(carry_in), .byte_op(byte_op),
    .sum(bcd_sum), .cout(bcd_cout)
  );

  always_comb begin
    unique case (opc)
      OPC_BIC: bw_kind = BW_CLR;
      OPC_BIS: bw_kind = BW_SET;
      OPC_XOR: bw_kind = BW_XOR;
      default: bw_kind = BW_AND;
    endcase
  end

  alu2_bitwise #(.DW(DW)) u_bitwise (
    .kind(bw_kind), .s(src_val), .d(dst_val), .res(bw_res)
  );

  // Result select and write/flag enables
  always_comb begin
    raw_res  = bw_res;
    do_wr    = 1'b1;
    do_flags = 1'b1;
    case (opc)
      OPC_MOV: begin raw_res = src_val; do_flags = 1'b0; end
      OPC_ADD, OPC_ADDC, OPC_SUBC, OPC_SUB: raw_res = as_sum;
      OPC_CMP: begin raw_res = as_sum; do_wr = 1'b0; end
      OPC_DADD: raw_res = bcd_sum;
      OPC_BIT: do_wr = 1'b0;
      OPC_BIC, OPC_BIS: do_flags = 1'b0;
      OPC_XOR, OPC_AND: ;
      default: begin do_wr = 1'b0; do_flags = 1'b0; end
    endcase
    fin_res = raw_res;
    if (byte_op) fin_res[DW-1:BW] = '0;
  end

  // Flag computation at the selected width
  always_comb begin
    r_msb  = byte_op ? fin_res[BW-1] : fin_res[DW-1];
    s_msb  = byte_op ? src_val[BW-1] : src_val[DW-1];
    d_msb  = byte_op ? dst_val[BW-1] : dst_val[DW-1];
    r_zero = (fin_res == '0);
    nf.n   = r_msb;
    nf.z   = r_zero;
    case (opc)
      OPC_DADD: begin nf.c = bcd_cout; nf.v = 1'b0; end
      OPC_XOR:  begin nf.c = ~r_zero;  nf.v = s_msb & d_msb; end
      OPC_BIT, OPC_AND: begin nf.c = ~r_zero; nf.v = 1'b0; end
      default:  begin nf.c = as_cout;  nf.v = as_ovf; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      wr_en   <= 1'b0;
      flag_en <= 1'b0;
      fq      <= '0;
    end else begin
      wr_en   <= in_valid & in_group & do_wr;
      flag_en <= in_valid & in_group & do_flags;
      if (in_valid && in_group) result <= fin_res;
      if (in_valid && in_group && do_flags) fq <= nf;
    end
  end

  assign flag_n = fq.n;
  assign flag_z = fq.z;
  assign flag_c = fq.c;
  assign flag_v = fq.v;

  // Flags move only on a cycle that reports a flag update
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !flag_en |-> $stable({flag_n, flag_z, flag_c, flag_v}));

  p_mov_no_flags_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 4'h4) |=> (wr_en && !flag_en));

  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 4'h9) |=> (!wr_en && flag_en));

  p_logic_cv_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_code == 4'hB || op_code == 4'hF)) |=> (!flag_v && (flag_c != flag_z)));

  p_xor_c_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 4'hE) |=> (flag_c != flag_z));

  p_byte_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && byte_op && in_group) |=> (result[DW-1:BW] == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || op_code[3:2] == 2'b00) |=> (!wr_en && !flag_en));

  p_zero_flag_r12: assert property (@(posedge clk) disable iff (rst)
    (flag_en && !byte_op && $past(!byte_op)) |-> (flag_z == (result == '0)));
endmodule

// File: tb/dual_op_alu_tb.sv
module dual_op_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = 4'h0;
  logic        byte_op = 1'b0;
  logic [15:0] src_val = '0, dst_val = '0;
  logic        carry_in = 1'b0;
  logic [15:0] result;
  logic        wr_en, flag_en, flag_n, flag_z, flag_c, flag_v;

  int n_chk = 0, n_bad = 0;
  logic m_n = 0, m_z = 0, m_c = 0, m_v = 0;
  logic [15:0] e_r;
  logic e_wr, e_fe;

  always #5 clk = ~clk;

  dual_op_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .byte_op(byte_op),
    .src_val(src_val), .dst_val(dst_val), .carry_in(carry_in), .result(result),
    .wr_en(wr_en), .flag_en(flag_en), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input [15:0] act, input [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model; updates model flags when the operation updates flags
  task automatic model(input [3:0] op, input bm, input [15:0] s, input [15:0] d, input ci);
    logic [15:0] mask, a, b, r;
    logic [16:0] sm;
    int w, cy, dg;
    logic n, z, c, v, sa, sb;
    w = bm ? 8 : 16;
    mask = bm ? 16'h00FF : 16'hFFFF;
    a = d & mask; b = s & mask;
    r = '0; c = 0; v = 0; e_wr = 1; e_fe = 1;
    case (op)
      4'h4: begin r = b; e_fe = 0; end
      4'h5, 4'h6, 4'h7, 4'h8, 4'h9: begin
        if (op >= 4'h7) b = ~b & mask;
        sm = {1'b0, a} + {1'b0, b} + ((op == 4'h5) ? 17'd0 : (op >= 4'h8) ? 17'd1 : {16'd0, ci});
        r = sm[15:0] & mask;
        c = sm[w];
        sa = a[w-1]; sb = b[w-1];
        v = (sa == sb) && (r[w-1] != sa);
        e_wr = (op != 4'h9);
      end
      4'hA: begin
        cy = ci;
        for (int k = 0; k < w/4; k++) begin
          dg = int'((a >> (4*k)) & 15) + int'((b >> (4*k)) & 15) + cy;
          if (dg > 9) begin dg = dg + 6; cy = 1; end else cy = 0;
          r = r | (16'(dg & 15) << (4*k));
        end
        c = cy[0];
      end
      4'hB, 4'hF: begin r = a & b; c = (r != 0); e_wr = (op == 4'hF); end
      4'hC: begin r = a & ~b & mask; e_fe = 0; end
      4'hD: begin r = a | b; e_fe = 0; end
      4'hE: begin r = a ^ b; c = (r != 0); v = a[w-1] & b[w-1]; end
      default: begin e_wr = 0; e_fe = 0; end
    endcase
    n = r[w-1]; z = (r == 0);
    e_r = r;
    if (e_fe) begin m_n = n; m_z = z; m_c = c; m_v = v; end
  endtask

  task automatic do_op(input string tag, input [3:0] op, input bm,
                       input [15:0] s, input [15:0] d, input ci, input vld = 1'b1);
    @(negedge clk);
    in_valid = vld; op_code = op; byte_op = bm; src_val = s; dst_val = d; carry_in = ci;
    if (vld) model(op, bm, s, d, ci); else begin e_wr = 0; e_fe = 0; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (vld && op[3:2] != 2'b00) chk({tag, " result"}, result, e_r);
    chk({tag, " wr_en"}, {15'd0, wr_en}, {15'd0, e_wr});
    chk({tag, " flag_en"}, {15'd0, flag_en}, {15'd0, e_fe});
    chk({tag, " flags NZCV"}, {12'd0, flag_n, flag_z, flag_c, flag_v}, {12'd0, m_n, m_z, m_c, m_v});
  endtask

  task automatic t_reset;
    chk("R11 reset result", result, 16'h0);
    chk("R11 reset enables/flags", {10'd0, wr_en, flag_en, flag_n, flag_z, flag_c, flag_v}, 16'h0);
  endtask

  task automatic t_byte_chain;
    do_op("R2 R9 byte add 75+C7", 4'h5, 1, 16'h0075, 16'h00C7, 0);
    chk("R2 byte add value", result, 16'h003C);
    chk("R2 byte add carry", {15'd0, flag_c}, 16'h1);
    do_op("R2 byte addc 0", 4'h6, 1, 16'h0000, 16'h003C, flag_c);
    chk("R2 addc value", result, 16'h003D);
    do_op("R7 byte xor FF", 4'hE, 1, 16'h00FF, 16'h003D, 0);
    chk("R7 xor value", result, 16'h00C2);
  endtask

  task automatic t_add_word;
    do_op("R2 R12 add overflow", 4'h5, 0, 16'h0001, 16'h7FFF, 0);
    chk("R2 overflow V/N", {14'd0, flag_n, flag_v}, 16'h3);
    do_op("R2 add carry wrap", 4'h5, 0, 16'h0001, 16'hFFFF, 1);
    do_op("R2 addc cin", 4'h6, 0, 16'h1234, 16'h1111, 1);
  endtask

  task automatic t_sub;
    do_op("R3 sub equal", 4'h8, 0, 16'h0005, 16'h0005, 0);
    chk("R3 sub zero no borrow", {14'd0, flag_z, flag_c}, 16'h3);
    do_op("R3 sub borrow", 4'h8, 0, 16'h0006, 16'h0005, 1);
    do_op("R3 subc cin0", 4'h7, 0, 16'h0001, 16'h8000, 0);
    do_op("R3 subc cin1", 4'h7, 0, 16'h0001, 16'h8000, 1);
  endtask

  task automatic t_cmp;
    do_op("R4 cmp", 4'h9, 0, 16'h0010, 16'h0003, 0);
    chk("R4 cmp no write", {15'd0, wr_en}, 16'h0);
  endtask

  task automatic t_dadd;
    do_op("R5 dadd word carry+zero", 4'hA, 0, 16'h0001, 16'h9999, 0);
    chk("R5 dadd zero and carry", {14'd0, flag_z, flag_c}, 16'h3);
    do_op("R5 dadd byte cin", 4'hA, 1, 16'h0000, 16'h0099, 1);
    chk("R5 R9 byte decimal wrap", result, 16'h0000);
    do_op("R5 dadd mid", 4'hA, 0, 16'h0258, 16'h0147, 0);
    chk("R5 dadd 0147+0258", result, 16'h0405);
  endtask

  task automatic t_logic;
    do_op("R6 and", 4'hF, 0, 16'hF0F0, 16'h8F00, 0);
    do_op("R6 bit zero", 4'hB, 0, 16'h00F0, 16'h0F00, 0);
    do_op("R7 xor both neg", 4'hE, 0, 16'h8001, 16'h8000, 0);
    chk("R7 xor V", {15'd0, flag_v}, 16'h1);
  endtask

  task automatic t_bic_bis;
    do_op("R8 set flags", 4'h5, 0, 16'h0001, 16'h7FFF, 0);
    do_op("R8 bic", 4'hC, 0, 16'h00FF, 16'h1234, 0);
    chk("R8 bic value", result, 16'h1200);
    do_op("R8 bis", 4'hD, 0, 16'h000F, 16'h0000, 0);
    do_op("R1 mov", 4'h4, 0, 16'hABCD, 16'h0000, 0);
    do_op("R1 R9 mov byte", 4'h4, 1, 16'h1234, 16'h0000, 0);
    chk("R9 mov byte upper", result, 16'h0034);
  endtask

  task automatic t_byte_mix;
    do_op("R9 byte add upper set", 4'h5, 1, 16'hAB40, 16'hCD40, 0);
    chk("R9 upper cleared", result, 16'h0080);
    chk("R9 V from bit7", {15'd0, flag_v}, 16'h1);
  endtask

  task automatic t_idle;
    do_op("R10 no valid", 4'h5, 0, 16'h1, 16'h1, 0, 1'b0);
    do_op("R10 unused opcode", 4'h2, 0, 16'h1, 16'h1, 0);
  endtask

  task automatic t_sweep;
    logic [31:0] lf;
    lf = 32'hACE1_1234;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      do_op("R12 sweep", lf[3:0] | 4'h4, lf[4], lf[31:16] ^ lf[15:0], {lf[7:0], lf[23:16]}, lf[9]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_byte_chain();
    t_add_word();
    t_sub();
    t_cmp();
    t_dadd();
    t_logic();
    t_bic_bis();
    t_byte_mix();
    t_idle();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule